// File: doc/BRIEF.md
# Character-Clock Raster Timing Generator

This block produces the raster timing for a text-era style display controller. It advances once per clock, and each clock stands for one eight-pixel character cell. A horizontal character counter and a vertical line counter are compared against a set of timing registers. These comparisons produce the display enable, the horizontal and vertical blanking, the two sync pulses, a line-compare interrupt pulse and a retrace status flag. The block also tracks the start address of every scanline: it begins each frame at a programmable start address and adds the line pitch at every line boundary.

The timing registers are plain inputs and hold biased values. The horizontal total is the character count less five, and the vertical total is the line count less two. The blank-end and sync-end values keep only a few low bits, which are matched against the low bits of the running counter. Each blank or sync signal is therefore a set/reset flag: a full-width match sets it and a low-bit match clears it. Every input is sampled into shadow registers at the last character of a frame, and also while reset is held, so a new mode always takes effect on a frame boundary.

All outputs are registered. The outputs seen in a given cycle describe the character the counters held in the previous cycle.

Top module: `crtc_timing_gen`

## Requirements
- R1: The horizontal counter runs from 0 through horizontal total + 4 and then wraps. The display enable output is high for the character at counter value c on line L exactly when c <= horizontal display end, L <= vertical display end and screen-off is clear.
- R2: The line counter advances at each horizontal wrap and runs from 0 through vertical total + 1. The line-compare interrupt is a one-cycle pulse for character 0 of the line whose number equals the line-compare value.
- R3: The horizontal blank flag is set after the character at which the counter equals horizontal display end. It is cleared after the character at which the low 7 counter bits equal the 7-bit blank-end value. The horizontal blank output for a character shows the flag as it stood before that character.
- R4: The horizontal sync flag is set after the character at which the full counter equals the 9-bit sync-start value. It is cleared after the character at which the low 5 counter bits equal the 5-bit sync-end value. The flag is shown the same way as in R3.
- R5: The vertical blank flag is updated only on the last character of a line. It is set when the line counter equals vertical display end, and cleared when the low 8 line bits equal the 8-bit blank-end value.
- R6: The vertical sync flag is updated only on the last character of a line. It is set when the line counter equals sync start, and cleared when the low 4 line bits equal the 4-bit sync-end value. The retrace output shows the raw vertical sync flag.
- R7: On the pins, a set polarity bit makes that sync active low, so the pin equals the flag XOR the polarity bit. A set disable bit forces the flag term to 0, which leaves the pin at its inactive level.
- R8: Screen-off forces both blank outputs high and display enable low. It has no effect on sync or on the interrupt.
- R9: The row address output is in 8-byte units and is ADDR_W bits wide, wrapping modulo 2^ADDR_W. At each line boundary inside a frame, it grows by twice the pitch value, because the pitch is in 16-byte units.
- R10: All inputs are taken into shadow registers only at the last character of a frame, or while reset is held. A change made mid-frame has no effect until the next frame, and the new frame's row address is the start input sampled at that point.
- R11: While reset is held, the counters are zero, display enable, blanks, retrace and interrupt are low, the row address is zero, and each sync pin sits at its inactive level as set by its polarity input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgHTotal | input | 9 | Characters per line minus 5 |
| cfgHDispEnd | input | 9 | Displayed characters minus 1 |
| cfgHBlankEnd | input | 7 | Low bits of the character where horizontal blank ends |
| cfgHSyncStart | input | 9 | Character where horizontal sync is set |
| cfgHSyncEnd | input | 5 | Low bits of the character where horizontal sync ends |
| cfgVTotal | input | 12 | Lines per frame minus 2 |
| cfgVDispEnd | input | 12 | Displayed lines minus 1 |
| cfgVBlankEnd | input | 8 | Low bits of the line where vertical blank ends |
| cfgVSyncStart | input | 12 | Line where vertical sync is set |
| cfgVSyncEnd | input | 4 | Low bits of the line where vertical sync ends |
| cfgLineCmp | input | 12 | Line that raises the interrupt pulse |
| cfgStartAddr | input | 21 | Frame start address, 8-byte units |
| cfgPitch | input | 10 | Line pitch, 16-byte units |
| cfgHSyncNeg | input | 1 | Horizontal sync active low |
| cfgVSyncNeg | input | 1 | Vertical sync active low |
| cfgHSyncOff | input | 1 | Hold horizontal sync inactive |
| cfgVSyncOff | input | 1 | Hold vertical sync inactive |
| cfgScreenOff | input | 1 | Force blanking |
| hSyncO | output | 1 | Horizontal sync pin |
| vSyncO | output | 1 | Vertical sync pin |
| hBlankO | output | 1 | Horizontal blank |
| vBlankO | output | 1 | Vertical blank |
| dispEnO | output | 1 | Display enable |
| lineIrqO | output | 1 | Line-compare interrupt pulse |
| retraceO | output | 1 | Vertical retrace status |
| rowAddrO | output | 21 | Start address of the current line, 8-byte units |

## Verification
The bench builds the block with its default parameters: 9-bit horizontal registers, 12-bit vertical registers, a 21-bit address and a 10-bit pitch. It programs short totals so that dozens of complete frames fit into a short run. One directed mode sets the largest horizontal total, which exercises the full 9-bit sync-start match and a 7-bit blank-end that wraps below display end. A start address near the top of the 21-bit range makes the row address wrap within a few lines.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

  // Strobes from the counter control to the datapath
  typedef struct packed {
    logic lineStart;  // counter on character 0
    logic lineEnd;    // last character of a line
    logic frameEnd;   // last character of the last line
    logic loadCfg;    // shadow registers take the inputs this edge
  } crtcStrobe_t;

  localparam int H_BIAS = 5;  // characters per line = register + H_BIAS
  localparam int V_BIAS = 2;  // lines per frame     = register + V_BIAS

endpackage

// File: rtl/crtc_ctrl.sv
module crtc_ctrl
  import crtc_pkg::*;
#(
  parameter int H_REG_W = 9,
  parameter int V_REG_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [H_REG_W-1:0] cfgHTotal,
  input  logic [V_REG_W-1:0] cfgVTotal,
  output logic [H_REG_W:0]   hCnt,
  output logic [V_REG_W:0]   vCnt,
  output crtcStrobe_t        strobe
);
  localparam int HCW = H_REG_W + 1;
  localparam int VCW = V_REG_W + 1;

  logic [H_REG_W-1:0] hTotSh;
  logic [V_REG_W-1:0] vTotSh;
  logic [HCW-1:0]     hLast;
  logic [VCW-1:0]     vLast;
  logic               lineEnd;
  logic               frameEnd;

  assign hLast    = HCW'(hTotSh) + HCW'(H_BIAS - 1);
  assign vLast    = VCW'(vTotSh) + VCW'(V_BIAS - 1);
  assign lineEnd  = (hCnt == hLast);
  assign frameEnd = lineEnd && (vCnt == vLast);

  always_comb begin
    strobe.lineStart = (hCnt == '0);
    strobe.lineEnd   = lineEnd;
    strobe.frameEnd  = frameEnd;
    strobe.loadCfg   = rst || frameEnd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt   <= '0;
      vCnt   <= '0;
      hTotSh <= cfgHTotal;
      vTotSh <= cfgVTotal;
    end else begin
      if (lineEnd) begin
        hCnt <= '0;
        if (frameEnd) vCnt <= '0;
        else          vCnt <= vCnt + 1'b1;
      end else begin
        hCnt <= hCnt + 1'b1;
      end
      if (frameEnd) begin
        hTotSh <= cfgHTotal;
        vTotSh <= cfgVTotal;
      end
    end
  end

  p_hcnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    hCnt <= hLast);
  p_line_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    lineEnd |=> (hCnt == '0));
  p_vcnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    vCnt <= vLast);
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    frameEnd |=> (vCnt == '0) && (hCnt == '0));

endmodule

// File: rtl/crtc_edge_flag.sv
module crtc_edge_flag #(
  parameter int CW = 10,
  parameter int SW = 9,
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [CW-1:0] cnt,
  input  logic [SW-1:0] startVal,
  input  logic [EW-1:0] endVal,
  output logic          flag
);
  // Full-width match sets, low-bit match clears; set wins a tie
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (adv) begin
      if (cnt == CW'(startVal))        flag <= 1'b1;
      else if (cnt[EW-1:0] == endVal)  flag <= 1'b0;
    end
  end
endmodule

// File: rtl/crtc_datapath.sv
module crtc_datapath
  import crtc_pkg::*;
#(
  parameter int H_REG_W = 9,
  parameter int V_REG_W = 12,
  parameter int ADDR_W  = 21,
  parameter int PITCH_W = 10,
  parameter int HBE_W   = 7,
  parameter int HSE_W   = 5,
  parameter int VBE_W   = 8,
  parameter int VSE_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  crtcStrobe_t        strobe,
  input  logic [H_REG_W:0]   hCnt,
  input  logic [V_REG_W:0]   vCnt,
  input  logic [H_REG_W-1:0] cfgHDispEnd,
  input  logic [HBE_W-1:0]   cfgHBlankEnd,
  input  logic [H_REG_W-1:0] cfgHSyncStart,
  input  logic [HSE_W-1:0]   cfgHSyncEnd,
  input  logic [V_REG_W-1:0] cfgVDispEnd,
  input  logic [VBE_W-1:0]   cfgVBlankEnd,
  input  logic [V_REG_W-1:0] cfgVSyncStart,
  input  logic [VSE_W-1:0]   cfgVSyncEnd,
  input  logic [V_REG_W-1:0] cfgLineCmp,
  input  logic [ADDR_W-1:0]  cfgStartAddr,
  input  logic [PITCH_W-1:0] cfgPitch,
  input  logic               cfgHSyncNeg,
  input  logic               cfgVSyncNeg,
  input  logic               cfgHSyncOff,
  input  logic               cfgVSyncOff,
  input  logic               cfgScreenOff,
  output logic               hSyncO,
  output logic               vSyncO,
  output logic               hBlankO,
  output logic               vBlankO,
  output logic               dispEnO,
  output logic               lineIrqO,
  output logic               retraceO,
  output logic [ADDR_W-1:0]  rowAddrO
);
  localparam int HCW = H_REG_W + 1;
  localparam int VCW = V_REG_W + 1;

  // Shadowed timing registers
  logic [H_REG_W-1:0] hDispSh, hSyncStartSh;
  logic [HBE_W-1:0]   hBlankEndSh;
  logic [HSE_W-1:0]   hSyncEndSh;
  logic [V_REG_W-1:0] vDispSh, vSyncStartSh, lineCmpSh;
  logic [VBE_W-1:0]   vBlankEndSh;
  logic [VSE_W-1:0]   vSyncEndSh;
  logic [PITCH_W-1:0] pitchSh;
  logic               hSyncNegSh, vSyncNegSh, hSyncOffSh, vSyncOffSh, screenOffSh;

  always_ff @(posedge clk) begin
    if (strobe.loadCfg) begin
      hDispSh      <= cfgHDispEnd;
      hBlankEndSh  <= cfgHBlankEnd;
      hSyncStartSh <= cfgHSyncStart;
      hSyncEndSh   <= cfgHSyncEnd;
      vDispSh      <= cfgVDispEnd;
      vBlankEndSh  <= cfgVBlankEnd;
      vSyncStartSh <= cfgVSyncStart;
      vSyncEndSh   <= cfgVSyncEnd;
      lineCmpSh    <= cfgLineCmp;
      pitchSh      <= cfgPitch;
      hSyncNegSh   <= cfgHSyncNeg;
      vSyncNegSh   <= cfgVSyncNeg;
      hSyncOffSh   <= cfgHSyncOff;
      vSyncOffSh   <= cfgVSyncOff;
      screenOffSh  <= cfgScreenOff;
    end
  end

  // Set/reset timing flags
  logic hBlankF, hSyncF, vBlankF, vSyncF;

  crtc_edge_flag #(.CW(HCW), .SW(H_REG_W), .EW(HBE_W)) u_hBlankFlag (
    .clk(clk), .rst(rst), .adv(1'b1), .cnt(hCnt),
    .startVal(hDispSh), .endVal(hBlankEndSh), .flag(hBlankF));

  crtc_edge_flag #(.CW(HCW), .SW(H_REG_W), .EW(HSE_W)) u_hSyncFlag (
    .clk(clk), .rst(rst), .adv(1'b1), .cnt(hCnt),
    .startVal(hSyncStartSh), .endVal(hSyncEndSh), .flag(hSyncF));

  crtc_edge_flag #(.CW(VCW), .SW(V_REG_W), .EW(VBE_W)) u_vBlankFlag (
    .clk(clk), .rst(rst), .adv(strobe.lineEnd), .cnt(vCnt),
    .startVal(vDispSh), .endVal(vBlankEndSh), .flag(vBlankF));

  crtc_edge_flag #(.CW(VCW), .SW(V_REG_W), .EW(VSE_W)) u_vSyncFlag (
    .clk(clk), .rst(rst), .adv(strobe.lineEnd), .cnt(vCnt),
    .startVal(vSyncStartSh), .endVal(vSyncEndSh), .flag(vSyncF));

  // Line start address stepping
  logic [ADDR_W-1:0] lineAddr;
  logic [ADDR_W-1:0] pitchStep;
  assign pitchStep = ADDR_W'({pitchSh, 1'b0});

  always_ff @(posedge clk) begin
    if (rst)                  lineAddr <= cfgStartAddr;
    else if (strobe.frameEnd) lineAddr <= cfgStartAddr;
    else if (strobe.lineEnd)  lineAddr <= lineAddr + pitchStep;
  end

  // Registered outputs
  logic hActive, vActive;
  assign hActive = (hCnt <= HCW'(hDispSh));
  assign vActive = (vCnt <= VCW'(vDispSh));

  always_ff @(posedge clk) begin
    if (rst) begin
      dispEnO  <= 1'b0;
      hBlankO  <= 1'b0;
      vBlankO  <= 1'b0;
      hSyncO   <= cfgHSyncNeg;
      vSyncO   <= cfgVSyncNeg;
      retraceO <= 1'b0;
      lineIrqO <= 1'b0;
      rowAddrO <= '0;
    end else begin
      dispEnO  <= hActive && vActive && !screenOffSh;
      hBlankO  <= hBlankF || screenOffSh;
      vBlankO  <= vBlankF || screenOffSh;
      hSyncO   <= (hSyncF && !hSyncOffSh) ^ hSyncNegSh;
      vSyncO   <= (vSyncF && !vSyncOffSh) ^ vSyncNegSh;
      retraceO <= vSyncF;
      lineIrqO <= strobe.lineStart && (vCnt == VCW'(lineCmpSh));
      rowAddrO <= lineAddr;
    end
  end

  p_irq_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    lineIrqO |=> !lineIrqO);
  p_sync_held_r7: assert property (@(posedge clk) disable iff (rst)
    hSyncOffSh |=> (hSyncO == $past(hSyncNegSh)));
  p_blank_forced_r8: assert property (@(posedge clk) disable iff (rst)
    screenOffSh |=> hBlankO && vBlankO && !dispEnO);
  p_row_step_r9: assert property (@(posedge clk) disable iff (rst)
    (strobe.lineEnd && !strobe.frameEnd) |=>
      (lineAddr == $past(lineAddr) + ADDR_W'({$past(pitchSh), 1'b0})));
  p_row_reload_r10: assert property (@(posedge clk) disable iff (rst)
    strobe.frameEnd |=> (lineAddr == $past(cfgStartAddr)));

endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
#(
  parameter int H_REG_W = 9,
  parameter int V_REG_W = 12,
  parameter int ADDR_W  = 21,
  parameter int PITCH_W = 10,
  parameter int HBE_W   = 7,
  parameter int HSE_W   = 5,
  parameter int VBE_W   = 8,
  parameter int VSE_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [H_REG_W-1:0] cfgHTotal,
  input  logic [H_REG_W-1:0] cfgHDispEnd,
  input  logic [HBE_W-1:0]   cfgHBlankEnd,
  input  logic [H_REG_W-1:0] cfgHSyncStart,
  input  logic [HSE_W-1:0]   cfgHSyncEnd,
  input  logic [V_REG_W-1:0] cfgVTotal,
  input  logic [V_REG_W-1:0] cfgVDispEnd,
  input  logic [VBE_W-1:0]   cfgVBlankEnd,
  input  logic [V_REG_W-1:0] cfgVSyncStart,
  input  logic [VSE_W-1:0]   cfgVSyncEnd,
  input  logic [V_REG_W-1:0] cfgLineCmp,
  input  logic [ADDR_W-1:0]  cfgStartAddr,
  input  logic [PITCH_W-1:0] cfgPitch,
  input  logic               cfgHSyncNeg,
  input  logic               cfgVSyncNeg,
  input  logic               cfgHSyncOff,
  input  logic               cfgVSyncOff,
  input  logic               cfgScreenOff,
  output logic               hSyncO,
  output logic               vSyncO,
  output logic               hBlankO,
  output logic               vBlankO,
  output logic               dispEnO,
  output logic               lineIrqO,
  output logic               retraceO,
  output logic [ADDR_W-1:0]  rowAddrO
);
  logic [H_REG_W:0] hCnt;
  logic [V_REG_W:0] vCnt;
  crtcStrobe_t      strobe;

  crtc_ctrl #(.H_REG_W(H_REG_W), .V_REG_W(V_REG_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfgHTotal(cfgHTotal), .cfgVTotal(cfgVTotal),
    .hCnt(hCnt), .vCnt(vCnt), .strobe(strobe));

  crtc_datapath #(
    .H_REG_W(H_REG_W), .V_REG_W(V_REG_W), .ADDR_W(ADDR_W), .PITCH_W(PITCH_W),
    .HBE_W(HBE_W), .HSE_W(HSE_W), .VBE_W(VBE_W), .VSE_W(VSE_W)
  ) u_datapath (
    .clk(clk), .rst(rst), .strobe(strobe), .hCnt(hCnt), .vCnt(vCnt),
    .cfgHDispEnd(cfgHDispEnd), .cfgHBlankEnd(cfgHBlankEnd),
    .cfgHSyncStart(cfgHSyncStart), .cfgHSyncEnd(cfgHSyncEnd),
    .cfgVDispEnd(cfgVDispEnd), .cfgVBlankEnd(cfgVBlankEnd),
    .cfgVSyncStart(cfgVSyncStart), .cfgVSyncEnd(cfgVSyncEnd),
    .cfgLineCmp(cfgLineCmp), .cfgStartAddr(cfgStartAddr), .cfgPitch(cfgPitch),
    .cfgHSyncNeg(cfgHSyncNeg), .cfgVSyncNeg(cfgVSyncNeg),
    .cfgHSyncOff(cfgHSyncOff), .cfgVSyncOff(cfgVSyncOff),
    .cfgScreenOff(cfgScreenOff),
    .hSyncO(hSyncO), .vSyncO(vSyncO), .hBlankO(hBlankO), .vBlankO(vBlankO),
    .dispEnO(dispEnO), .lineIrqO(lineIrqO), .retraceO(retraceO),
    .rowAddrO(rowAddrO));

endmodule

// File: tb/crtc_timing_gen_bench.sv
module crtc_timing_gen_bench;
  localparam int CLK_HALF = 10;  // 50 MHz
  localparam int ADDR_MASK = 32'h1F_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  cfgHTotal, cfgHDispEnd, cfgHSyncStart;
  logic [6:0]  cfgHBlankEnd;
  logic [4:0]  cfgHSyncEnd;
  logic [11:0] cfgVTotal, cfgVDispEnd, cfgVSyncStart, cfgLineCmp;
  logic [7:0]  cfgVBlankEnd;
  logic [3:0]  cfgVSyncEnd;
  logic [20:0] cfgStartAddr;
  logic [9:0]  cfgPitch;
  logic        cfgHSyncNeg, cfgVSyncNeg, cfgHSyncOff, cfgVSyncOff, cfgScreenOff;
  logic        hSyncO, vSyncO, hBlankO, vBlankO, dispEnO, lineIrqO, retraceO;
  logic [20:0] rowAddrO;

  always #(CLK_HALF) clk = ~clk;

  crtc_timing_gen u_crtc_timing_gen (
    .clk(clk), .rst(rst),
    .cfgHTotal(cfgHTotal), .cfgHDispEnd(cfgHDispEnd), .cfgHBlankEnd(cfgHBlankEnd),
    .cfgHSyncStart(cfgHSyncStart), .cfgHSyncEnd(cfgHSyncEnd),
    .cfgVTotal(cfgVTotal), .cfgVDispEnd(cfgVDispEnd), .cfgVBlankEnd(cfgVBlankEnd),
    .cfgVSyncStart(cfgVSyncStart), .cfgVSyncEnd(cfgVSyncEnd), .cfgLineCmp(cfgLineCmp),
    .cfgStartAddr(cfgStartAddr), .cfgPitch(cfgPitch),
    .cfgHSyncNeg(cfgHSyncNeg), .cfgVSyncNeg(cfgVSyncNeg),
    .cfgHSyncOff(cfgHSyncOff), .cfgVSyncOff(cfgVSyncOff), .cfgScreenOff(cfgScreenOff),
    .hSyncO(hSyncO), .vSyncO(vSyncO), .hBlankO(hBlankO), .vBlankO(vBlankO),
    .dispEnO(dispEnO), .lineIrqO(lineIrqO), .retraceO(retraceO), .rowAddrO(rowAddrO));

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // Reference state, built from the requirements
  int mH, mV, hbF, hsF, vbF, vsF, lineAddr;
  int sHT, sHD, sHB, sHSS, sHSE, sVT, sVD, sVB, sVSS, sVSE, sLC, sP;
  int sHN, sVN, sHO, sVO, sOff;
  int eDe, eHb, eVb, eHs, eVs, eRet, eIrq, eRow;
  bit eRst, ePend, eOff, eHPin, eVPin, midChange;

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic loadShadow();
    sHT = cfgHTotal; sHD = cfgHDispEnd; sHB = cfgHBlankEnd; sHSS = cfgHSyncStart;
    sHSE = cfgHSyncEnd; sVT = cfgVTotal; sVD = cfgVDispEnd; sVB = cfgVBlankEnd;
    sVSS = cfgVSyncStart; sVSE = cfgVSyncEnd; sLC = cfgLineCmp; sP = cfgPitch;
    sHN = cfgHSyncNeg; sVN = cfgVSyncNeg; sHO = cfgHSyncOff; sVO = cfgVSyncOff;
    sOff = cfgScreenOff;
    midChange = 0;
  endtask

  // Predict what the next rising edge produces
  task automatic modelStep(bit r);
    bit le, fe;
    if (r) begin
      mH = 0; mV = 0; hbF = 0; hsF = 0; vbF = 0; vsF = 0;
      loadShadow();
      lineAddr = cfgStartAddr;
      eRst = 1; ePend = 0;
      eDe = 0; eHb = 0; eVb = 0; eRet = 0; eIrq = 0; eRow = 0;
      eHs = cfgHSyncNeg; eVs = cfgVSyncNeg;
    end else begin
      eRst = 0; ePend = midChange; eOff = sOff != 0;
      eHPin = (sHN | sHO) != 0; eVPin = (sVN | sVO) != 0;
      eDe  = (mH <= sHD && mV <= sVD && sOff == 0) ? 1 : 0;
      eHb  = hbF | sOff;
      eVb  = vbF | sOff;
      eHs  = (hsF & (sHO ^ 1)) ^ sHN;
      eVs  = (vsF & (sVO ^ 1)) ^ sVN;
      eRet = vsF;
      eIrq = (mH == 0 && mV == sLC) ? 1 : 0;
      eRow = lineAddr;
      le = (mH == sHT + 4);
      fe = le && (mV == sVT + 1);
      if (mH == sHD) hbF = 1; else if ((mH & 127) == sHB) hbF = 0;
      if (mH == sHSS) hsF = 1; else if ((mH & 31) == sHSE) hsF = 0;
      if (le) begin
        if (mV == sVD) vbF = 1; else if ((mV & 255) == sVB) vbF = 0;
        if (mV == sVSS) vsF = 1; else if ((mV & 15) == sVSE) vsF = 0;
      end
      if (fe)      lineAddr = cfgStartAddr;
      else if (le) lineAddr = (lineAddr + 2 * sP) & ADDR_MASK;
      if (le) begin
        mH = 0;
        mV = fe ? 0 : mV + 1;
      end else begin
        mH = mH + 1;
      end
      if (fe) loadShadow();
    end
  endtask

  task automatic compareAll();
    if (eRst) begin
      chk("R11", "dispEn",  dispEnO,  eDe);
      chk("R11", "hBlank",  hBlankO,  eHb);
      chk("R11", "vBlank",  vBlankO,  eVb);
      chk("R11", "hSync",   hSyncO,   eHs);
      chk("R11", "vSync",   vSyncO,   eVs);
      chk("R11", "retrace", retraceO, eRet);
      chk("R11", "lineIrq", lineIrqO, eIrq);
      chk("R11", "rowAddr", int'(rowAddrO), eRow);
    end else begin
      chk(ePend ? "R10" : "R1", "dispEn", dispEnO, eDe);
      chk(eOff ? "R8" : "R3", "hBlank", hBlankO, eHb);
      chk(eOff ? "R8" : "R5", "vBlank", vBlankO, eVb);
      chk(eHPin ? "R7" : "R4", "hSync", hSyncO, eHs);
      chk(eVPin ? "R7" : "R6", "vSync", vSyncO, eVs);
      chk("R6", "retrace", retraceO, eRet);
      chk("R2", "lineIrq", lineIrqO, eIrq);
      chk("R9", "rowAddr", int'(rowAddrO), eRow);
    end
  endtask

  // kind: 0 random, 1 widest line, 2 address wrap, 3 forced off and inverted syncs
  task automatic setCfg(int kind);
    int hT, hD, hSS, vT, vD, vSS;
    case (kind)
      1: begin
        cfgHTotal = 9'd511; cfgHDispEnd = 9'd400; cfgHBlankEnd = 7'((511 + 4) & 127);
        cfgHSyncStart = 9'd450; cfgHSyncEnd = 5'(460 & 31);
        cfgVTotal = 12'd2; cfgVDispEnd = 12'd1; cfgVBlankEnd = 8'd3;
        cfgVSyncStart = 12'd2; cfgVSyncEnd = 4'd3; cfgLineCmp = 12'd2;
        cfgStartAddr = 21'h0_1000; cfgPitch = 10'd80;
        {cfgHSyncNeg, cfgVSyncNeg, cfgHSyncOff, cfgVSyncOff, cfgScreenOff} = '0;
      end
      2: begin
        cfgHTotal = 9'd5; cfgHDispEnd = 9'd4; cfgHBlankEnd = 7'd9;
        cfgHSyncStart = 9'd6; cfgHSyncEnd = 5'd8;
        cfgVTotal = 12'd10; cfgVDispEnd = 12'd7; cfgVBlankEnd = 8'd11;
        cfgVSyncStart = 12'd8; cfgVSyncEnd = 4'd10; cfgLineCmp = 12'd8;
        cfgStartAddr = 21'h1F_FC00; cfgPitch = 10'd1023;
        {cfgHSyncNeg, cfgVSyncNeg, cfgHSyncOff, cfgVSyncOff, cfgScreenOff} = '0;
      end
      3: begin
        cfgHSyncNeg = 1'b1; cfgVSyncNeg = 1'b1; cfgHSyncOff = 1'b0;
        cfgVSyncOff = 1'b1; cfgScreenOff = 1'b1;
      end
      default: begin
        hT = 3 + int'($urandom % 18);
        hD = int'($urandom % (hT + 3));
        hSS = hD + 1 + int'($urandom % (hT + 4 - hD));
        vT = 2 + int'($urandom % 14);
        vD = int'($urandom % (vT + 1));
        vSS = vD + 1 + int'($urandom % (vT + 1 - vD));
        cfgHTotal = 9'(hT); cfgHDispEnd = 9'(hD);
        cfgHBlankEnd = ($urandom % 4 == 0) ? 7'($urandom) : 7'((hT + 4) & 127);
        cfgHSyncStart = 9'(hSS);
        cfgHSyncEnd = 5'((hSS + 1 + int'($urandom % 5)) & 31);
        cfgVTotal = 12'(vT); cfgVDispEnd = 12'(vD);
        cfgVBlankEnd = ($urandom % 4 == 0) ? 8'($urandom) : 8'((vT + 1) & 255);
        cfgVSyncStart = 12'(vSS);
        cfgVSyncEnd = 4'((vSS + 1 + int'($urandom % 3)) & 15);
        cfgLineCmp = ($urandom % 3 == 0) ? 12'($urandom % (vT + 2)) : 12'(vD + 1);
        cfgStartAddr = 21'($urandom);
        cfgPitch = 10'(1 + $urandom % 1023);
        cfgHSyncNeg = ($urandom % 4 == 0); cfgVSyncNeg = ($urandom % 4 == 0);
        cfgHSyncOff = ($urandom % 6 == 0); cfgVSyncOff = ($urandom % 6 == 0);
        cfgScreenOff = ($urandom % 8 == 0);
      end
    endcase
  endtask

  // One compare per output per cycle; optional config change at cycle cfgAt
  task automatic runCycles(int n, bit rstVal, int cfgAt, int kind);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compareAll();
      rst = rstVal;
      if (k == cfgAt) begin
        setCfg(kind);
        if (!rstVal) midChange = 1;
      end
      modelStep(rstVal);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    setCfg(0);
    {cfgHSyncNeg, cfgVSyncNeg, cfgHSyncOff, cfgVSyncOff, cfgScreenOff} = 5'b10000;
    rst = 1'b1;
    modelStep(1);
    runCycles(3, 1, -1, 0);           // R11 reset state
    runCycles(600, 0, -1, 0);
    for (int i = 0; i < 40; i++)      // R10 mid-frame changes
      runCycles(700, 0, int'($urandom % 300), 0);
    runCycles(600, 0, 5, 3);          // R7 and R8 directed
    runCycles(4, 1, 0, 0);            // R11 reset during operation
    runCycles(800, 0, -1, 0);
    runCycles(2400, 0, 3, 2);         // R9 address wraparound
    runCycles(4, 1, 0, 1);            // widest line loaded in reset
    runCycles(4400, 0, -1, 0);        // R3, R4 full-width and low-bit compares
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(2 * CLK_HALF * 150000);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule